// File: doc/BRIEF.md
# Local Interrupt Pin Conditioner

This block turns level updates on the two local interrupt pins into requests for the local processor. Each pin has its own local vector table entry. The entry holds a vector, a delivery mode, a trigger selector and a mask bit. A level update is a one-cycle strobe that comes with the pin's present level. Depending on the entry, the update raises one of these outputs: a fixed-vector request, an NMI pulse, an SMI pulse or an error pulse. An entry in ExtINT mode instead drives the shared ExtINT level. When the controller enable is low, the entries are skipped: pin 0 drives the ExtINT level directly and pin 1 raises NMI.

Each pin has a line state machine with the states `LN_IDLE` and `LN_ACTIVE`. A high update on a fixed-class entry moves the line from idle to active (the arm transition). A low update moves it back to idle (the release transition). Pin 0 also has a remote-IRR state machine with the states `RI_CLEAR` and `RI_WAIT`. A level-mode send moves it to `RI_WAIT` (the hold transition). An end-of-interrupt strobe whose vector equals pin 0's entry vector returns it to `RI_CLEAR` (the retire transition). Both entries are loaded through a write port. All outputs are registered: a request caused by an update at one clock edge is visible after that same edge.

Top module: `lint_cond`

## Requirements
- R1: After reset all request outputs and `extint_lvl` are low, both line states are `LN_IDLE`, remote IRR is `RI_CLEAR`, and both entries read as vector 0, fixed mode, edge, with the mask set. A high update then produces no request.
- R2: The entry word has these fields: bits [7:0] vector, bits [10:8] delivery mode, bit 11 level trigger (1 means level), bit 12 mask. The delivery modes are 000 fixed, 001 lowest-priority, 010 SMI, 011 reserved, 100 NMI, 101 INIT, 110 startup, 111 ExtINT. With the entry in fixed mode and edge trigger, a high update raises `fix_req[p]` and puts the entry vector on that pin's vector output, but only when the line is `LN_IDLE`. The update then makes the line `LN_ACTIVE`.
- R3: A low update on a fixed or INIT entry returns the line to `LN_IDLE` and sends nothing.
- R4: Pin 1 always behaves as edge-triggered, whatever value its level-trigger bit holds.
- R5: With pin 0 in level trigger, a high update sends only when remote IRR is `RI_CLEAR`, and the send moves remote IRR to `RI_WAIT`. The high update sets the line to `LN_ACTIVE` either way.
- R6: An end-of-interrupt strobe whose vector equals pin 0's entry vector clears remote IRR. A strobe with any other vector leaves it set. When a strobe and a high update arrive in the same cycle, the update is judged against the remote-IRR value held before that cycle.
- R7: INIT mode behaves exactly as fixed mode.
- R8: In SMI or NMI mode, every high update pulses `smi_req` or `nmi_req` for one cycle. Low updates send nothing and do not change the line state. At most one of fixed, NMI, SMI and error is raised per pin per cycle.
- R9: In ExtINT mode, a high update sets `extint_lvl` and a low update clears it. If both pins update in the same cycle, a set takes precedence over a clear.
- R10: Lowest-priority, startup and reserved modes pulse `cfg_err[p]` on any update, send nothing and leave the line state unchanged.
- R11: A set mask bit suppresses fixed, INIT, NMI and SMI requests. The line state still follows the updates, and remote IRR is not set.
- R12: With `apic_en` low, a pin 0 update copies its level to `extint_lvl`, a pin 1 high update pulses `nmi_req`, and the entries, the line states and remote IRR are left untouched.
- R13: An entry write affects updates from the next cycle onward. An update in the same cycle as the write uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| lint_upd | input | 2 | per-pin level-update strobe |
| lint_lvl | input | 2 | per-pin level carried by the update |
| apic_en | input | 1 | controller enable; low selects the bypass routing |
| lvt_we | input | 1 | entry write strobe |
| lvt_sel | input | 1 | entry selected for the write |
| lvt_wdata | input | 13 | entry write data (fields as in R2) |
| eoi_stb | input | 1 | end-of-interrupt strobe |
| eoi_vec | input | 8 | vector being retired |
| fix_req | output | 2 | per-pin fixed-vector request pulse |
| fix_vec0 | output | 8 | vector sent with pin 0's request, 0 when there is none |
| fix_vec1 | output | 8 | vector sent with pin 1's request, 0 when there is none |
| nmi_req | output | 1 | NMI request pulse |
| smi_req | output | 1 | SMI request pulse |
| extint_lvl | output | 1 | ExtINT request level |
| cfg_err | output | 2 | per-pin pulse for an unsupported delivery mode |

## Verification
Repeated high updates without an intervening low update tell edge behaviour apart from per-update behaviour: fixed mode must stay silent, while NMI and SMI must pulse again. Pin 0 level-mode sequences add end-of-interrupt strobes with matching and non-matching vectors, which separates correct remote-IRR gating from plain edge detection. Masked entries, disabled-controller traffic and writes in the same cycle as an update each show state that changes without any visible request. The bench catches this by checking what the next update sends. A seeded random mix of writes, updates on both pins and strobes is compared every cycle against a bench model of the line and remote-IRR state.

// File: rtl/lint_pkg.sv
package lint_pkg;
    localparam int VEC_W  = 8;
    localparam int NPIN   = 2;
    localparam int SEL_W  = (NPIN > 1) ? $clog2(NPIN) : 1;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWP   = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV    = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_START  = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef struct packed {
        logic             mask;
        logic             lvl_trig;
        dmode_e           mode;
        logic [VEC_W-1:0] vec;
    } lvt_t;

    localparam int LVT_W = $bits(lvt_t);

    typedef enum logic {LN_IDLE, LN_ACTIVE} line_e;
    typedef enum logic {RI_CLEAR, RI_WAIT} rirr_e;

    function automatic lvt_t lvt_reset_val();
        lvt_t r;
        r          = '0;
        r.mode     = DM_FIXED;
        r.mask     = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/lint_lvt_bank.sv
module lint_lvt_bank
    import lint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  lvt_t                  wdata_i,
    output lvt_t [NPIN-1:0]       ent_o
);
    for (genvar p = 0; p < NPIN; p++) begin : g_ent
        lvt_t ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= lvt_reset_val();
            end else if (we_i && (sel_i == SEL_W'(p))) begin
                ent_q <= wdata_i;
            end
        end
        assign ent_o[p] = ent_q;
    end
endmodule

// File: rtl/lint_pin_fsm.sv
module lint_pin_fsm
    import lint_pkg::*;
#(
    parameter bit IS_LINT1 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic             lvl_i,
    input  logic             apic_en_i,
    input  lvt_t             entry_i,
    input  logic             eoi_hit_i,
    output logic             fix_req_o,
    output logic [VEC_W-1:0] fix_vec_o,
    output logic             nmi_req_o,
    output logic             smi_req_o,
    output logic             err_o,
    output logic             ext_set_o,
    output logic             ext_clr_o
);
    line_e ln_q, ln_d;
    rirr_e ri_q, ri_d;
    logic  send_fix, send_nmi, send_smi, send_err;
    logic  level_mode, is_fixed, is_bad;

    assign level_mode = entry_i.lvl_trig && !IS_LINT1;
    assign is_fixed   = (entry_i.mode == DM_FIXED) || (entry_i.mode == DM_INIT);
    assign is_bad     = (entry_i.mode == DM_LOWP) || (entry_i.mode == DM_START) ||
                        (entry_i.mode == DM_RSV);

    // next-state and request decision
    always_comb begin
        ln_d      = ln_q;
        ri_d      = (eoi_hit_i && !IS_LINT1) ? RI_CLEAR : ri_q;
        send_fix  = 1'b0;
        send_nmi  = 1'b0;
        send_smi  = 1'b0;
        send_err  = 1'b0;
        ext_set_o = 1'b0;
        ext_clr_o = 1'b0;
        if (upd_i) begin
            if (!apic_en_i) begin
                if (IS_LINT1) begin
                    send_nmi = lvl_i;
                end else begin
                    ext_set_o = lvl_i;
                    ext_clr_o = !lvl_i;
                end
            end else begin
                unique case (entry_i.mode)
                    DM_FIXED, DM_INIT: begin
                        if (!lvl_i) begin
                            ln_d = LN_IDLE;
                        end else begin
                            ln_d = LN_ACTIVE;
                            if (!entry_i.mask) begin
                                if (level_mode) begin
                                    if (ri_q == RI_CLEAR) begin
                                        send_fix = 1'b1;
                                        ri_d     = RI_WAIT;
                                    end
                                end else begin
                                    send_fix = (ln_q == LN_IDLE);
                                end
                            end
                        end
                    end
                    DM_SMI:    send_smi = lvl_i && !entry_i.mask;
                    DM_NMI:    send_nmi = lvl_i && !entry_i.mask;
                    DM_EXTINT: begin
                        ext_set_o = lvl_i;
                        ext_clr_o = !lvl_i;
                    end
                    DM_LOWP, DM_START, DM_RSV: send_err = 1'b1;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= LN_IDLE;
            ri_q <= RI_CLEAR;
        end else begin
            ln_q <= ln_d;
            ri_q <= IS_LINT1 ? RI_CLEAR : ri_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_req_o <= 1'b0;
            fix_vec_o <= '0;
            nmi_req_o <= 1'b0;
            smi_req_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            fix_req_o <= send_fix;
            fix_vec_o <= send_fix ? entry_i.vec : '0;
            nmi_req_o <= send_nmi;
            smi_req_o <= send_smi;
            err_o     <= send_err;
        end
    end

    // R2: an armed edge line stays silent on another high update
    a_r2_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (apic_en_i && upd_i && lvl_i && is_fixed && !level_mode && ln_q == LN_ACTIVE)
        |=> !fix_req_o);

    // R3: low update on a fixed-class entry never raises a request
    a_r3_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (apic_en_i && upd_i && !lvl_i && !is_bad)
        |=> !fix_req_o && !nmi_req_o && !smi_req_o);

    // R5: held remote IRR blocks a level-mode resend
    a_r5_remote_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (apic_en_i && upd_i && lvl_i && is_fixed && level_mode && ri_q == RI_WAIT)
        |=> !fix_req_o);

    // R8: one request kind per pin per cycle
    a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fix_req_o, nmi_req_o, smi_req_o, err_o}));

    // R10: unsupported modes flag an error and send nothing
    a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (apic_en_i && upd_i && is_bad) |=> err_o && !fix_req_o);

    // R11: mask suppresses every maskable request
    a_r11_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (apic_en_i && upd_i && entry_i.mask)
        |=> !fix_req_o && !nmi_req_o && !smi_req_o);

    // R12: bypass never produces fixed, SMI or error
    a_r12_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!apic_en_i) |=> !fix_req_o && !smi_req_o && !err_o);
endmodule

// File: rtl/lint_cond.sv
module lint_cond
    import lint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  lint_upd,
    input  logic [1:0]  lint_lvl,
    input  logic        apic_en,
    input  logic        lvt_we,
    input  logic        lvt_sel,
    input  logic [12:0] lvt_wdata,
    input  logic        eoi_stb,
    input  logic [7:0]  eoi_vec,
    output logic [1:0]  fix_req,
    output logic [7:0]  fix_vec0,
    output logic [7:0]  fix_vec1,
    output logic        nmi_req,
    output logic        smi_req,
    output logic        extint_lvl,
    output logic [1:0]  cfg_err
);
    lvt_t [NPIN-1:0]       ent;
    logic [NPIN-1:0]       nmi_p, smi_p, set_p, clr_p;
    logic [VEC_W-1:0]      vec_p [NPIN];
    logic                  eoi_hit;

    lint_lvt_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lvt_we),
        .sel_i   (SEL_W'(lvt_sel)),
        .wdata_i (lvt_t'(lvt_wdata)),
        .ent_o   (ent)
    );

    assign eoi_hit = eoi_stb && (eoi_vec == ent[0].vec);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        lint_pin_fsm #(.IS_LINT1(p == 1)) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_i     (lint_upd[p]),
            .lvl_i     (lint_lvl[p]),
            .apic_en_i (apic_en),
            .entry_i   (ent[p]),
            .eoi_hit_i ((p == 0) ? eoi_hit : 1'b0),
            .fix_req_o (fix_req[p]),
            .fix_vec_o (vec_p[p]),
            .nmi_req_o (nmi_p[p]),
            .smi_req_o (smi_p[p]),
            .err_o     (cfg_err[p]),
            .ext_set_o (set_p[p]),
            .ext_clr_o (clr_p[p])
        );
    end

    assign fix_vec0 = vec_p[0];
    assign fix_vec1 = vec_p[1];
    assign nmi_req  = |nmi_p;
    assign smi_req  = |smi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            extint_lvl <= 1'b0;
        end else if (|set_p) begin
            extint_lvl <= 1'b1;
        end else if (|clr_p) begin
            extint_lvl <= 1'b0;
        end
    end

    // R12: bypassed pin 0 update copies its level to the ExtINT output
    a_r12_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!apic_en && lint_upd[0] && !lint_upd[1]) |=> (extint_lvl == $past(lint_lvl[0])));

    // R9: with no update at all the ExtINT level holds
    a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lint_upd == 2'b00) |=> $stable(extint_lvl));
endmodule

// File: tb/test_lint_cond.sv
module test_lint_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lint_upd = '0;
    logic [1:0]  lint_lvl = '0;
    logic        apic_en = 1'b1;
    logic        lvt_we = 1'b0;
    logic        lvt_sel = 1'b0;
    logic [12:0] lvt_wdata = '0;
    logic        eoi_stb = 1'b0;
    logic [7:0]  eoi_vec = '0;
    logic [1:0]  fix_req;
    logic [7:0]  fix_vec0, fix_vec1;
    logic        nmi_req, smi_req, extint_lvl;
    logic [1:0]  cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [12:0] m_ent [2];
    bit          m_ln  [2];
    bit          m_ri;
    bit          m_ext;

    always #5 clk = ~clk;

    lint_cond i_lint_cond (
        .clk(clk), .rst_n(rst_n), .lint_upd(lint_upd), .lint_lvl(lint_lvl),
        .apic_en(apic_en), .lvt_we(lvt_we), .lvt_sel(lvt_sel), .lvt_wdata(lvt_wdata),
        .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .fix_req(fix_req), .fix_vec0(fix_vec0),
        .fix_vec1(fix_vec1), .nmi_req(nmi_req), .smi_req(smi_req),
        .extint_lvl(extint_lvl), .cfg_err(cfg_err)
    );

    function automatic logic [12:0] mk(input logic [7:0] v, input logic [2:0] m,
                                       input bit lv, input bit mk_b);
        return {mk_b, lv, m, v};
    endfunction

    task automatic step(input logic [1:0] upd, input logic [1:0] lvl, input bit en,
                        input bit we, input bit sel, input logic [12:0] wd,
                        input bit eo, input logic [7:0] ev, input string tag);
        logic [1:0] e_fix, e_err;
        logic [7:0] e_vec [2];
        bit e_nmi, e_smi, any_set, any_clr, ri_n;
        bit ln_n [2];
        logic [25:0] act, exp;
        @(negedge clk);
        lint_upd = upd; lint_lvl = lvl; apic_en = en; lvt_we = we; lvt_sel = sel;
        lvt_wdata = wd; eoi_stb = eo; eoi_vec = ev;
        e_fix = '0; e_err = '0; e_vec[0] = '0; e_vec[1] = '0;
        e_nmi = 0; e_smi = 0; any_set = 0; any_clr = 0;
        ln_n[0] = m_ln[0]; ln_n[1] = m_ln[1];
        ri_n = (eo && ev == m_ent[0][7:0]) ? 1'b0 : m_ri;
        for (int p = 0; p < 2; p++) begin
            logic [2:0] md;
            bit msk, lvm;
            md  = m_ent[p][10:8];
            msk = m_ent[p][12];
            lvm = m_ent[p][11] && (p == 0);
            if (upd[p]) begin
                if (!en) begin
                    if (p == 1) e_nmi |= lvl[p];
                    else begin any_set |= lvl[p]; any_clr |= !lvl[p]; end
                end else if (md == 3'b000 || md == 3'b101) begin
                    if (!lvl[p]) ln_n[p] = 0;
                    else begin
                        ln_n[p] = 1;
                        if (!msk) begin
                            if (lvm) begin
                                if (!m_ri) begin e_fix[p] = 1; ri_n = 1; end
                            end else if (!m_ln[p]) e_fix[p] = 1;
                        end
                    end
                end else if (md == 3'b010) e_smi |= lvl[p] && !msk;
                else if (md == 3'b100) e_nmi |= lvl[p] && !msk;
                else if (md == 3'b111) begin any_set |= lvl[p]; any_clr |= !lvl[p]; end
                else e_err[p] = 1;
                if (e_fix[p]) e_vec[p] = m_ent[p][7:0];
            end
        end
        m_ln[0] = ln_n[0]; m_ln[1] = ln_n[1]; m_ri = ri_n;
        if (any_set) m_ext = 1; else if (any_clr) m_ext = 0;
        if (we) m_ent[sel] = wd;
        @(posedge clk);
        #2;
        act = {fix_req, fix_vec0, fix_vec1, nmi_req, smi_req, extint_lvl, cfg_err};
        exp = {e_fix, e_vec[0], e_vec[1], e_nmi, e_smi, m_ext, e_err};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got fix=%b v0=%h v1=%h nmi=%b smi=%b ext=%b err=%b, expected fix=%b v0=%h v1=%h nmi=%b smi=%b ext=%b err=%b",
                tag, fix_req, fix_vec0, fix_vec1, nmi_req, smi_req, extint_lvl, cfg_err,
                e_fix, e_vec[0], e_vec[1], e_nmi, e_smi, m_ext, e_err);
        end
    endtask

    task automatic upd0(input bit lv, input string tag);
        step(2'b01, {1'b0, lv}, 1, 0, 0, '0, 0, '0, tag);
    endtask
    task automatic upd1(input bit lv, input string tag);
        step(2'b10, {lv, 1'b0}, 1, 0, 0, '0, 0, '0, tag);
    endtask
    task automatic wr(input bit sel, input logic [12:0] wd);
        step(2'b00, 2'b00, 1, 1, sel, wd, 0, '0, "R13 write");
    endtask
    task automatic eoi(input logic [7:0] v, input string tag);
        step(2'b00, 2'b00, 1, 0, 0, '0, 1, v, tag);
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 2; p++) begin m_ent[p] = 13'h1000; m_ln[p] = 0; end
        m_ri = 0; m_ext = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and masked default entries
        step(2'b00, 2'b00, 1, 0, 0, '0, 0, '0, "R1 idle");
        step(2'b11, 2'b11, 1, 0, 0, '0, 0, '0, "R1 masked default");
        step(2'b11, 2'b00, 1, 0, 0, '0, 0, '0, "R1 release");
        // R2/R3 edge fixed on pin 0
        wr(0, mk(8'h41, 3'b000, 0, 0));
        upd0(0, "R3 low");
        upd0(1, "R2 first high sends");
        upd0(1, "R2 second high silent");
        upd0(0, "R3 release");
        upd0(1, "R2 rearmed");
        // R4 pin 1 level bit ignored
        wr(1, mk(8'h52, 3'b000, 1, 0));
        upd1(0, "R4 low");
        upd1(1, "R4 first");
        upd1(1, "R4 no repeat");
        // R5/R6 level on pin 0
        wr(0, mk(8'h60, 3'b000, 1, 0));
        upd0(0, "R5 low");
        upd0(1, "R5 send");
        upd0(0, "R5 low keeps remote");
        upd0(1, "R5 blocked");
        eoi(8'h61, "R6 nonmatch");
        upd0(1, "R6 still blocked");
        eoi(8'h60, "R6 match");
        upd0(1, "R6 resend");
        step(2'b01, 2'b01, 1, 0, 0, '0, 1, 8'h60, "R6 same cycle");
        upd0(1, "R6 after same cycle");
        // R7 INIT
        wr(0, mk(8'h33, 3'b101, 0, 0));
        upd0(0, "R7 low");
        upd0(1, "R7 send");
        upd0(1, "R7 silent");
        // R8 NMI/SMI
        wr(1, mk(8'h02, 3'b100, 0, 0));
        upd1(1, "R8 nmi");
        upd1(1, "R8 nmi again");
        upd1(0, "R8 nmi low");
        wr(0, mk(8'h00, 3'b010, 0, 0));
        upd0(1, "R8 smi");
        upd0(0, "R8 smi low");
        // R9 ExtINT
        wr(0, mk(8'h00, 3'b111, 0, 0));
        wr(1, mk(8'h00, 3'b111, 0, 0));
        upd0(1, "R9 set");
        upd0(0, "R9 clear");
        step(2'b11, 2'b10, 1, 0, 0, '0, 0, '0, "R9 set wins");
        upd1(0, "R9 clear pin1");
        // R10 unsupported modes
        wr(1, mk(8'h44, 3'b001, 0, 0));
        upd1(1, "R10 lowest");
        wr(1, mk(8'h44, 3'b110, 0, 0));
        upd1(0, "R10 startup low");
        wr(1, mk(8'h44, 3'b011, 0, 0));
        upd1(1, "R10 reserved");
        wr(1, mk(8'h44, 3'b000, 0, 0));
        upd1(1, "R10 line unchanged");
        // R11 mask
        wr(0, mk(8'h70, 3'b000, 0, 1));
        upd0(0, "R11 low");
        upd0(1, "R11 masked");
        wr(0, mk(8'h70, 3'b000, 0, 0));
        upd0(1, "R11 latch still armed");
        wr(1, mk(8'h02, 3'b100, 0, 1));
        upd1(1, "R11 masked nmi");
        // R12 bypass
        wr(0, mk(8'h45, 3'b000, 0, 0));
        upd0(0, "R12 prep");
        step(2'b01, 2'b01, 0, 0, 0, '0, 0, '0, "R12 pin0 ext set");
        step(2'b10, 2'b10, 0, 0, 0, '0, 0, '0, "R12 pin1 nmi");
        step(2'b10, 2'b00, 0, 0, 0, '0, 0, '0, "R12 pin1 low");
        step(2'b01, 2'b00, 0, 0, 0, '0, 0, '0, "R12 pin0 ext clear");
        step(2'b01, 2'b01, 0, 0, 0, '0, 0, '0, "R12 pin0 high again");
        upd0(1, "R12 latch untouched");
        // R13 write with update same cycle
        upd0(0, "R13 prep");
        step(2'b01, 2'b01, 1, 1, 0, mk(8'h99, 3'b001, 0, 0), 0, '0, "R13 old entry used");
        upd0(1, "R13 new entry");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [12:0] wd;
            logic [7:0]  ev;
            bit we, en;
            wd = mk(8'h40 | 8'($urandom % 2), 3'($urandom), 1'($urandom), ($urandom % 4) == 0);
            we = ($urandom % 8) == 0;
            en = ($urandom % 10) != 0;
            ev = 8'h40 | 8'($urandom % 2);
            step(2'($urandom), 2'($urandom), en, we, 1'($urandom), wd,
                 ($urandom % 4) == 0, ev, "R13 random");
        end
        step(2'b00, 2'b00, 1, 0, 0, '0, 0, '0, "R1 final idle");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule